// File: doc/BRIEF.md
# Register-File Datapath with ALU and Data RAM

This block is the execution half of a single-cycle processor. A control word arrives on its inputs every cycle. The control word selects two source registers, an ALU function, whether the RAM is written, where register write-back data comes from, and whether a destination register is loaded. There is no fetch, decode or program counter. The control word comes from outside the block, and all state changes on one rising clock edge.

The register file has four registers and two combinational read ports. The ALU combines the two read values and produces a result with four flags. The data RAM has 2^DATA_W words, which is as many as a register value can address. The RAM address comes from read port A and the RAM write data comes from read port B. The ALU never touches memory. A value reaches memory only through a register, and it comes back only through the write-back select.

Top module: `dp_core`

## Requirements
- R1: While rst_ni is low, every register reads as zero on both read ports, and they stay zero after release until written.
- R2: a_o always shows the register selected by rd_a_sel_i, and b_o always shows the register selected by rd_b_sel_i, with no clock delay.
- R3: On a rising edge with wr_en_i = 1, the register at wr_sel_i takes the value of wb_data_o, and no other register changes.
- R4: On a rising edge with wr_en_i = 0, no register changes, whatever the other control inputs are.
- R5: The arithmetic codes of func_i (hex) are: 00 F=A, 01 F=A+1, 02 F=A+B, 03 F=A+B+1, 04 F=A+~B, 05 F=A-B (as A+~B+1), 06 F=A-1 (as A plus all ones). All are modulo 2^DATA_W. cry_o is the carry out of the top bit of that addition.
- R6: The logic and shift codes of func_i (hex) are: 08 AND, 09 OR, 0A XOR, 0B NOT A, 0C F=B, 10 F=B shifted right one place with a zero filled in, 18 F=B shifted left one place with a zero filled in. For these codes, cry_o = 0 and ovf_o = 0.
- R7: ovf_o flags two's-complement overflow of the arithmetic. neg_o equals the top bit of f_o. zero_o is 1 exactly when f_o is all zeros.
- R8: Any func_i code not listed in R5 or R6 gives f_o = A with cry_o = 0 and ovf_o = 0.
- R9: On a rising edge with mem_we_i = 1, the RAM word addressed by a_o takes b_o. The RAM output shows the word at a_o at all times, and before a write it still shows the old word.
- R10: wb_data_o is f_o when wb_mem_i = 0 and the RAM word addressed by a_o when wb_mem_i = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low, clears the registers |
| rd_a_sel_i | input | 2 | Register index for read port A |
| rd_b_sel_i | input | 2 | Register index for read port B |
| wr_sel_i | input | 2 | Destination register index |
| wr_en_i | input | 1 | Load the destination register |
| func_i | input | 5 | ALU function code |
| mem_we_i | input | 1 | Write B into the RAM at address A |
| wb_mem_i | input | 1 | Write-back source: 0 = ALU, 1 = RAM |
| a_o | output | DATA_W | Read port A value |
| b_o | output | DATA_W | Read port B value |
| f_o | output | DATA_W | ALU result |
| ovf_o | output | 1 | Signed overflow flag |
| cry_o | output | 1 | Carry flag |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| wb_data_o | output | DATA_W | Data the destination register will load |

## Verification
A register loaded with a wrong value, or loaded when it should not be, shows up on a_o or b_o in the first cycle that reads it. Through the ALU it also corrupts f_o and the flags in that same cycle. A RAM word written at the wrong address, or with the wrong data, stays hidden until a later cycle puts that address on port A. At that point wb_data_o differs as soon as wb_mem_i is set. Because of this delay, the stimulus first stores into every address and then loads words back.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic [4:0] {
    OP_PASS_A = 5'h00,
    OP_INC    = 5'h01,
    OP_ADD    = 5'h02,
    OP_ADD_C  = 5'h03,
    OP_ADD_NB = 5'h04,
    OP_SUB    = 5'h05,
    OP_DEC    = 5'h06,
    OP_AND    = 5'h08,
    OP_OR     = 5'h09,
    OP_XOR    = 5'h0A,
    OP_NOT    = 5'h0B,
    OP_PASS_B = 5'h0C,
    OP_SHR_B  = 5'h10,
    OP_SHL_B  = 5'h18
  } alu_op_e;

  function automatic logic op_is_logic(logic [4:0] op);
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_PASS_B, OP_SHR_B, OP_SHL_B: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_arith(logic [4:0] op);
    return op <= 5'h06;
  endfunction
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DATA_W = 8,
  parameter int REG_N  = 4,
  localparam int SEL_W = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  rd_a_sel_i,
  input  logic [SEL_W-1:0]  rd_b_sel_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o
);
  logic [REG_N-1:0][DATA_W-1:0] regs_q;
  logic [REG_N-1:0]             load;

  for (genvar k = 0; k < REG_N; k++) begin : g_reg
    // decoder gated by the write enable
    assign load[k] = wr_en_i && (wr_sel_i == SEL_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      regs_q[k] <= '0;
      else if (load[k]) regs_q[k] <= wr_data_i;
    end
  end

  assign rd_a_o = regs_q[rd_a_sel_i];
  assign rd_b_o = regs_q[rd_b_sel_i];

  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> regs_q[$past(wr_sel_i)] == $past(wr_data_i));

  a_r4_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_q));

  a_r3_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load));
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [4:0]        func_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] f_o,
  output logic              ovf_o,
  output logic              cry_o,
  output logic              neg_o,
  output logic              zero_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] y_op;
  logic              cin;
  logic              arith;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] log_res;

  always_comb begin
    y_op  = '0;
    cin   = 1'b0;
    arith = 1'b1;
    case (func_i)
      OP_PASS_A: begin y_op = '0;    cin = 1'b0; end
      OP_INC:    begin y_op = '0;    cin = 1'b1; end
      OP_ADD:    begin y_op = b_i;   cin = 1'b0; end
      OP_ADD_C:  begin y_op = b_i;   cin = 1'b1; end
      OP_ADD_NB: begin y_op = ~b_i;  cin = 1'b0; end
      OP_SUB:    begin y_op = ~b_i;  cin = 1'b1; end
      OP_DEC:    begin y_op = '1;    cin = 1'b0; end
      default:   arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, a_i} + {1'b0, y_op} + {{DATA_W{1'b0}}, cin};

  always_comb begin
    case (func_i)
      OP_AND:    log_res = a_i & b_i;
      OP_OR:     log_res = a_i | b_i;
      OP_XOR:    log_res = a_i ^ b_i;
      OP_NOT:    log_res = ~a_i;
      OP_PASS_B: log_res = b_i;
      OP_SHR_B:  log_res = {1'b0, b_i[MSB:1]};
      OP_SHL_B:  log_res = {b_i[MSB-1:0], 1'b0};
      default:   log_res = a_i;
    endcase
  end

  assign f_o    = arith ? sum[MSB:0] : log_res;
  assign cry_o  = arith & sum[DATA_W];
  assign ovf_o  = arith & (a_i[MSB] == y_op[MSB]) & (sum[MSB] != a_i[MSB]);
  assign neg_o  = f_o[MSB];
  assign zero_o = ~|f_o;
endmodule

// File: rtl/dp_ram.sv
module dp_ram #(
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];

  a_r9_store_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/dp_core.sv
module dp_core
  import dp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_N  = 4,
  localparam int SEL_W = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  rd_a_sel_i,
  input  logic [SEL_W-1:0]  rd_b_sel_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic              wr_en_i,
  input  logic [4:0]        func_i,
  input  logic              mem_we_i,
  input  logic              wb_mem_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o,
  output logic [DATA_W-1:0] f_o,
  output logic              ovf_o,
  output logic              cry_o,
  output logic              neg_o,
  output logic              zero_o,
  output logic [DATA_W-1:0] wb_data_o
);
  logic [DATA_W-1:0] ram_rd;

  dp_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_a_sel_i(rd_a_sel_i),
    .rd_b_sel_i(rd_b_sel_i),
    .wr_sel_i  (wr_sel_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wb_data_o),
    .rd_a_o    (a_o),
    .rd_b_o    (b_o)
  );

  dp_alu #(.DATA_W(DATA_W)) u_alu (
    .func_i(func_i),
    .a_i   (a_o),
    .b_i   (b_o),
    .f_o   (f_o),
    .ovf_o (ovf_o),
    .cry_o (cry_o),
    .neg_o (neg_o),
    .zero_o(zero_o)
  );

  // memory addressed by port A, fed by port B
  dp_ram #(.DATA_W(DATA_W)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mem_we_i),
    .addr_i (a_o),
    .wdata_i(b_o),
    .rdata_o(ram_rd)
  );

  assign wb_data_o = wb_mem_i ? ram_rd : f_o;

  a_r5_sub_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_i == OP_SUB && a_o == b_o) |-> (zero_o && cry_o && !ovf_o));

  a_r6_logic_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_is_logic(func_i) |-> (!cry_o && !ovf_o));

  a_r8_unused_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_is_logic(func_i) && !op_is_arith(func_i)) |-> (f_o == a_o && !cry_o && !ovf_o));

  a_r10_alu_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wb_mem_i && wr_en_i) |=> (a_o == $past(f_o)) || (rd_a_sel_i != $past(wr_sel_i)));
endmodule

// File: tb/sim_dp_core.sv
module sim_dp_core;
  import dp_pkg::*;
  localparam int CLK_P = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] aa, ba, da;
  logic we, mw, md;
  logic [4:0] fs;
  logic [W-1:0] a_o, b_o, f_o, wb_o;
  logic v_o, c_o, n_o, z_o;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [W-1:0] m_reg [4];
  logic [W-1:0] m_ram [256];

  always #(CLK_P/2) clk = ~clk;

  dp_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .rd_a_sel_i(aa), .rd_b_sel_i(ba),
    .wr_sel_i(da), .wr_en_i(we), .func_i(fs), .mem_we_i(mw), .wb_mem_i(md),
    .a_o(a_o), .b_o(b_o), .f_o(f_o), .ovf_o(v_o), .cry_o(c_o),
    .neg_o(n_o), .zero_o(z_o), .wb_data_o(wb_o)
  );

  // returns {v, c, f}
  function automatic logic [W+1:0] alu_ref(logic [4:0] op, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] y, f;
    int cin, us, ss;
    logic is_ar;
    is_ar = 1'b1; y = '0; cin = 0; f = a;
    case (op)
      5'h00: begin y = 8'h00; cin = 0; end
      5'h01: begin y = 8'h00; cin = 1; end
      5'h02: begin y = b;     cin = 0; end
      5'h03: begin y = b;     cin = 1; end
      5'h04: begin y = ~b;    cin = 0; end
      5'h05: begin y = ~b;    cin = 1; end
      5'h06: begin y = 8'hFF; cin = 0; end
      default: is_ar = 1'b0;
    endcase
    if (is_ar) begin
      us = int'(a) + int'(y) + cin;
      ss = int'($signed(a)) + int'($signed(y)) + cin;
      return {(ss > 127 || ss < -128), (us > 255), us[W-1:0]};
    end
    case (op)
      5'h08: f = a & b;
      5'h09: f = a | b;
      5'h0A: f = a ^ b;
      5'h0B: f = ~a;
      5'h0C: f = b;
      5'h10: f = b >> 1;
      5'h18: f = b << 1;
      default: f = a;
    endcase
    return {2'b00, f};
  endfunction

  function automatic string op_tag(logic [4:0] op);
    if (op <= 5'h06) return "R5";
    case (op)
      5'h08, 5'h09, 5'h0A, 5'h0B, 5'h0C, 5'h10, 5'h18: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(logic [1:0] a_s, logic [1:0] b_s, logic [1:0] d_s, logic w,
                      logic [4:0] op, logic m_w, logic m_d, string rtag);
    logic [W-1:0] ea, eb, ewb;
    logic [W+1:0] r;
    string ftag;
    @(negedge clk);
    aa = a_s; ba = b_s; da = d_s; we = w; fs = op; mw = m_w; md = m_d;
    #1;
    ea = m_reg[a_s]; eb = m_reg[b_s];
    r = alu_ref(op, ea, eb);
    ewb = m_d ? m_ram[ea] : r[W-1:0];
    ftag = op_tag(op);
    chk(rtag, "a_o", int'(a_o), int'(ea));
    chk(rtag, "b_o", int'(b_o), int'(eb));
    chk(ftag, "f_o", int'(f_o), int'(r[W-1:0]));
    chk((ftag == "R5") ? "R5" : ftag, "cry_o", int'(c_o), int'(r[W]));
    chk("R7", "ovf_o", int'(v_o), int'(r[W+1]));
    chk("R7", "neg_o", int'(n_o), int'(r[W-1]));
    chk("R7", "zero_o", int'(z_o), int'(r[W-1:0] == '0));
    chk("R10", "wb_data_o", int'(wb_o), int'(ewb));
    @(posedge clk);
    if (w) m_reg[d_s] = ewb;
    if (m_w) m_ram[ea] = eb;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] ops [14];
    void'($urandom(32'd4711));
    ops = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h06,
            5'h08, 5'h09, 5'h0A, 5'h0B, 5'h0C, 5'h10, 5'h18};
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    for (int i = 0; i < 256; i++) m_ram[i] = '0;
    aa = 0; ba = 0; da = 0; we = 0; fs = 0; mw = 0; md = 0;
    rst_n = 1'b0;
    #(CLK_P * 2 + 2);
    // R1: registers read zero during reset
    for (int i = 0; i < 4; i++) begin
      aa = 2'(i); #1;
      chk("R1", "a_o in reset", int'(a_o), 0);
    end
    @(negedge clk); rst_n = 1'b1;
    step(0, 1, 0, 0, OP_PASS_A, 0, 0, "R1");
    step(2, 3, 0, 0, OP_PASS_A, 0, 0, "R1");

    // fill every RAM word: R0 address, R1 data (R9)
    for (int i = 0; i < 256; i++) begin
      step(0, 1, 0, 0, OP_PASS_A, 1, 0, "R2");
      step(0, 1, 0, 1, OP_INC, 0, 0, "R2");
      step(0, 1, 1, 1, OP_ADD_C, 0, 0, "R2");
    end
    // load back through the RAM path (R9, R10)
    for (int i = 0; i < 24; i++) begin
      step(0, 1, 2, 1, OP_PASS_A, 0, 1, "R9");
      step(2, 0, 0, 1, OP_INC, 0, 0, "R9");
    end
    // store then load at a new address, same cycle read shows old word (R9)
    step(0, 3, 0, 1, OP_PASS_A, 1, 1, "R9");
    step(0, 0, 3, 1, OP_PASS_A, 0, 1, "R9");

    // R3: write lands only in destination
    step(1, 2, 3, 1, OP_XOR, 0, 0, "R3");
    step(3, 0, 0, 0, OP_PASS_A, 0, 0, "R3");
    step(1, 2, 0, 0, OP_PASS_A, 0, 0, "R3");
    // R4: no load with write enable low
    step(3, 3, 3, 0, OP_INC, 0, 1, "R4");
    step(3, 2, 0, 0, OP_PASS_A, 0, 0, "R4");

    // R7 corners: zero, carry, overflow
    step(3, 3, 3, 1, OP_SUB, 0, 0, "R2");
    step(3, 3, 3, 1, OP_DEC, 0, 0, "R2");
    step(3, 3, 3, 1, OP_SHR_B, 0, 0, "R2");
    step(3, 3, 2, 1, OP_INC, 0, 0, "R2");
    step(2, 2, 1, 1, OP_ADD, 0, 0, "R2");
    step(3, 3, 1, 1, OP_ADD_C, 0, 0, "R2");
    step(2, 3, 1, 1, OP_ADD_NB, 0, 0, "R2");
    step(2, 2, 1, 1, OP_SHL_B, 0, 0, "R2");
    // R8: unused codes
    step(2, 1, 0, 1, 5'h07, 0, 0, "R2");
    step(3, 1, 0, 1, 5'h1F, 0, 0, "R2");

    // constrained random control words
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] op;
      op = ($urandom % 8 == 0) ? 5'($urandom % 32) : ops[$urandom % 14];
      step(2'($urandom), 2'($urandom), 2'($urandom), ($urandom % 10) < 7, op,
           ($urandom % 10) == 0, ($urandom % 10) < 3, "R2");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule